// File: doc/BRIEF.md
# DMA Channel Command Semaphore Sequencer

This block is a single DMA channel front end. It walks a linked chain of command descriptors held in memory, and a counting semaphore decides how far it goes. Software first writes the address of the first descriptor into the next-command register. It then adds a count to the semaphore. While the count is nonzero, the channel reads a three-word descriptor through a simple one-word read port and presents the transfer it describes on a request/acknowledge stub. It then signals completion and, if the descriptor says so, follows its link to the next descriptor.

Each descriptor decides for itself whether its completion consumes one unit of the semaphore and whether the chain continues. Software can top up the semaphore while the channel runs to extend the work. It can poll the count, which falls to zero once every counted command is finished. An idle output shows when the channel is neither fetching nor executing.

Top module: `dmaseq_chan_top`

## Requirements
- R1: After reset the channel is idle, the semaphore and the next-command register read zero, and neither the descriptor port nor the transfer stub is requesting.
- R2: When the channel is idle and not halted and the semaphore is nonzero, it starts fetching from the next-command address. It reads word 0 (link address) at that address, word 1 (command word) at address+4 and word 2 (buffer address) at address+8. It holds each request and its address until the matching valid beat arrives.
- R3: After the fetch, the transfer request is raised with the transfer count (command word bits 31:16) and the buffer address, and it is held until acknowledged. The cycle after the acknowledge, cmd_done_o pulses for exactly one cycle. cmd_irq_o is high with it when command bit 2 is set.
- R4: A finished command lowers the semaphore by one only when its decrement bit (command bit 1) is set. In no other case does the semaphore change except through a software write.
- R5: When a finished command has its chain bit (command bit 0) set, its link word is copied into the next-command register. If the semaphore is still nonzero, the next fetch starts there at once.
- R6: When the semaphore reaches zero after a chained command, the channel goes idle with the next-command register holding the link. A later semaphore write resumes the chain from there.
- R7: A write to the semaphore register adds the low 8 bits of the write data to the count. Writes made while the channel is running extend the current chain.
- R8: A semaphore addition and a command decrement that fall in the same cycle combine into one net update.
- R9: When a command without the chain bit finishes, the channel goes idle and keeps its remaining count. It fetches nothing more until the next-command register is written.
- R10: The 8-bit semaphore saturates at 255 on addition and never goes below zero.
- R11: Register map by reg_addr_i: 0 is the next-command address (read/write), 1 is the semaphore (reads the count, writes add), 2 is the address of the current descriptor (read only), and 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select for read and write |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on reg_addr_i) |
| dsc_req_o | output | 1 | Descriptor word read request |
| dsc_addr_o | output | 32 | Byte address of the descriptor word requested |
| dsc_valid_i | input | 1 | Read data valid for the pending request |
| dsc_rdata_i | input | 32 | Descriptor word read data |
| xfer_req_o | output | 1 | Transfer request to the execution stub |
| xfer_count_o | output | 16 | Transfer count of the current command |
| xfer_buf_o | output | 32 | Buffer address of the current command |
| xfer_ack_i | input | 1 | Transfer accepted and complete |
| cmd_done_o | output | 1 | One-cycle pulse per finished command |
| cmd_irq_o | output | 1 | Interrupt-flagged completion, coincident with cmd_done_o |
| idle_o | output | 1 | Channel neither fetching nor executing |

## Verification
The bench builds the block with its defaults: 32-bit addresses and data, a 16-bit transfer count and an 8-bit semaphore. With an 8-bit count, saturation takes only two register writes (200 then 100), while chains of up to five commands stay far below the limit. The descriptor memory model answers every other cycle, and acknowledges can be held or placed by hand. This lets the bench land a semaphore write in the same cycle as a decrementing completion, and top up the count during a held transfer.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_EXEC  = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_e;

  // command word flag positions
  localparam int unsigned CMD_CHAIN_BIT = 0;
  localparam int unsigned CMD_DEC_BIT   = 1;
  localparam int unsigned CMD_IRQ_BIT   = 2;

  // descriptor word order
  localparam int unsigned DW_LINK = 0;
  localparam int unsigned DW_CMD  = 1;
  localparam int unsigned DW_BUF  = 2;
  localparam int unsigned DESC_WORDS = 3;

  // register select codes
  localparam logic [1:0] RA_NEXT = 2'd0;
  localparam logic [1:0] RA_SEMA = 2'd1;
  localparam logic [1:0] RA_CUR  = 2'd2;

  typedef struct packed {
    logic chain;
    logic dec;
    logic irq;
  } cmd_flags_t;

endpackage

// File: rtl/dmaseq_sema.sv
module dmaseq_sema #(
  parameter int unsigned SEMA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              add_en_i,
  input  logic [SEMA_W-1:0] add_val_i,
  input  logic              dec_en_i,
  output logic [SEMA_W-1:0] count_o,
  output logic [SEMA_W-1:0] count_nxt_o
);

  localparam int unsigned SUM_W = SEMA_W + 1;
  localparam logic [SUM_W-1:0] CAP = {1'b0, {SEMA_W{1'b1}}};

  logic [SEMA_W-1:0] count_q, count_d;
  logic [SUM_W-1:0]  sum;
  logic              upd;

  always_comb begin
    sum = {1'b0, count_q};
    if (add_en_i) begin
      sum = sum + {1'b0, add_val_i};
    end
    // a decrement against an empty count is dropped
    if (dec_en_i && (count_q != '0)) begin
      sum = sum - SUM_W'(1);
    end
    if (sum > CAP) begin
      count_d = {SEMA_W{1'b1}};
    end else begin
      count_d = sum[SEMA_W-1:0];
    end
    upd = add_en_i | dec_en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
    end else if (upd) begin
      count_q <= count_d;
    end
  end

  assign count_o     = count_q;
  assign count_nxt_o = count_d;

endmodule

// File: rtl/dmaseq_fetch.sv
module dmaseq_fetch #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WORDS  = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic [ADDR_W-1:0]             base_i,
  input  logic                          active_i,
  input  logic                          valid_i,
  input  logic [DATA_W-1:0]             rdata_i,
  output logic [ADDR_W-1:0]             addr_o,
  output logic [ADDR_W-1:0]             base_o,
  output logic                          last_o,
  output logic [WORDS-1:0][DATA_W-1:0]  words_o
);

  localparam int unsigned IDX_W      = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int unsigned WORD_SHIFT = $clog2(DATA_W / 8);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic              beat;

  assign beat   = active_i & valid_i;
  assign last_o = beat & (idx_q == LAST_IDX);

  always_comb begin
    idx_d  = idx_q;
    base_d = base_q;
    if (start_i) begin
      base_d = base_i;
      idx_d  = '0;
    end else if (beat) begin
      idx_d = (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      base_q <= '0;
    end else if (start_i | beat) begin
      idx_q  <= idx_d;
      base_q <= base_d;
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [DATA_W-1:0] word_q;
    logic              cap_en;
    assign cap_en = beat & (idx_q == IDX_W'(w));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        word_q <= '0;
      end else if (cap_en) begin
        word_q <= rdata_i;
      end
    end
    assign words_o[w] = word_q;
  end

  assign addr_o = base_q + (ADDR_W'(idx_q) << WORD_SHIFT);
  assign base_o = base_q;

endmodule

// File: rtl/dmaseq_ctrl.sv
module dmaseq_ctrl
  import dmaseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SEMA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEMA_W-1:0] sema_i,
  input  logic [SEMA_W-1:0] sema_nxt_i,
  input  logic              nxt_wr_i,
  input  logic [ADDR_W-1:0] nxt_wdata_i,
  input  logic              fetch_last_i,
  input  logic              xfer_ack_i,
  input  cmd_flags_t        flags_i,
  input  logic [ADDR_W-1:0] link_i,
  output seq_state_e        state_o,
  output logic              start_o,
  output logic [ADDR_W-1:0] base_o,
  output logic              dec_o,
  output logic              done_o,
  output logic              irq_o,
  output logic [ADDR_W-1:0] nxt_o,
  output logic              halted_o
);

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] nxt_q, nxt_d;
  logic              halted_q, halted_d;

  always_comb begin
    state_d  = state_q;
    nxt_d    = nxt_q;
    halted_d = halted_q;
    start_o  = 1'b0;
    base_o   = nxt_q;
    dec_o    = 1'b0;
    done_o   = 1'b0;
    irq_o    = 1'b0;

    if (nxt_wr_i) begin
      nxt_d    = nxt_wdata_i;
      halted_d = 1'b0;
    end

    unique case (state_q)
      ST_IDLE: begin
        if ((sema_i != '0) && !halted_q) begin
          start_o = 1'b1;
          base_o  = nxt_q;
          state_d = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (fetch_last_i) begin
          state_d = ST_EXEC;
        end
      end
      ST_EXEC: begin
        if (xfer_ack_i) begin
          state_d = ST_DONE;
        end
      end
      ST_DONE: begin
        done_o = 1'b1;
        irq_o  = flags_i.irq;
        dec_o  = flags_i.dec;
        if (flags_i.chain) begin
          nxt_d = link_i;
          if (sema_nxt_i != '0) begin
            start_o = 1'b1;
            base_o  = link_i;
            state_d = ST_FETCH;
          end else begin
            state_d = ST_IDLE;
          end
        end else begin
          halted_d = 1'b1;
          state_d  = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      nxt_q    <= '0;
      halted_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      nxt_q    <= nxt_d;
      halted_q <= halted_d;
    end
  end

  assign state_o  = state_q;
  assign nxt_o    = nxt_q;
  assign halted_o = halted_q;

endmodule

// File: rtl/dmaseq_chan_top.sv
module dmaseq_chan_top
  import dmaseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned SEMA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              dsc_req_o,
  output logic [ADDR_W-1:0] dsc_addr_o,
  input  logic              dsc_valid_i,
  input  logic [DATA_W-1:0] dsc_rdata_i,
  output logic              xfer_req_o,
  output logic [CNT_W-1:0]  xfer_count_o,
  output logic [ADDR_W-1:0] xfer_buf_o,
  input  logic              xfer_ack_i,
  output logic              cmd_done_o,
  output logic              cmd_irq_o,
  output logic              idle_o
);

  localparam int unsigned CNT_LSB = DATA_W - CNT_W;

  seq_state_e                    state;
  logic                          sema_wr, nxt_wr;
  logic [SEMA_W-1:0]             sema_cnt, sema_nxt;
  logic                          fetch_start, fetch_last;
  logic [ADDR_W-1:0]             fetch_base, cur_addr, nxt_addr;
  logic [DESC_WORDS-1:0][DATA_W-1:0] dwords;
  cmd_flags_t                    flags;
  logic                          seq_dec, seq_halted;
  logic                          unused_bits;

  assign sema_wr = reg_wr_i & (reg_addr_i == RA_SEMA);
  assign nxt_wr  = reg_wr_i & (reg_addr_i == RA_NEXT);

  assign flags.chain = dwords[DW_CMD][CMD_CHAIN_BIT];
  assign flags.dec   = dwords[DW_CMD][CMD_DEC_BIT];
  assign flags.irq   = dwords[DW_CMD][CMD_IRQ_BIT];

  dmaseq_sema #(
    .SEMA_W(SEMA_W)
  ) sema_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .add_en_i   (sema_wr),
    .add_val_i  (reg_wdata_i[SEMA_W-1:0]),
    .dec_en_i   (seq_dec),
    .count_o    (sema_cnt),
    .count_nxt_o(sema_nxt)
  );

  dmaseq_fetch #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .WORDS (DESC_WORDS)
  ) fetch_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (fetch_start),
    .base_i  (fetch_base),
    .active_i(dsc_req_o),
    .valid_i (dsc_valid_i),
    .rdata_i (dsc_rdata_i),
    .addr_o  (dsc_addr_o),
    .base_o  (cur_addr),
    .last_o  (fetch_last),
    .words_o (dwords)
  );

  dmaseq_ctrl #(
    .ADDR_W(ADDR_W),
    .SEMA_W(SEMA_W)
  ) ctrl_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sema_i      (sema_cnt),
    .sema_nxt_i  (sema_nxt),
    .nxt_wr_i    (nxt_wr),
    .nxt_wdata_i (reg_wdata_i[ADDR_W-1:0]),
    .fetch_last_i(fetch_last),
    .xfer_ack_i  (xfer_ack_i),
    .flags_i     (flags),
    .link_i      (dwords[DW_LINK][ADDR_W-1:0]),
    .state_o     (state),
    .start_o     (fetch_start),
    .base_o      (fetch_base),
    .dec_o       (seq_dec),
    .done_o      (cmd_done_o),
    .irq_o       (cmd_irq_o),
    .nxt_o       (nxt_addr),
    .halted_o    (seq_halted)
  );

  assign dsc_req_o    = (state == ST_FETCH);
  assign xfer_req_o   = (state == ST_EXEC);
  assign idle_o       = (state == ST_IDLE);
  assign xfer_count_o = dwords[DW_CMD][CNT_LSB +: CNT_W];
  assign xfer_buf_o   = dwords[DW_BUF][ADDR_W-1:0];

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      RA_NEXT: reg_rdata_o[ADDR_W-1:0] = nxt_addr;
      RA_SEMA: reg_rdata_o[SEMA_W-1:0] = sema_cnt;
      RA_CUR:  reg_rdata_o[ADDR_W-1:0] = cur_addr;
      default: reg_rdata_o = '0;
    endcase
  end

  assign unused_bits = ^{dwords[DW_CMD][CNT_LSB-1:CMD_IRQ_BIT+1], dwords, reg_wdata_i};

endmodule

// File: rtl/dmaseq_chan_chk.sv
module dmaseq_chan_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SEMA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wr_i,
  input logic [1:0]        reg_addr_i,
  input logic              idle_i,
  input logic              halted_i,
  input logic [SEMA_W-1:0] sema_i,
  input logic              dsc_req_i,
  input logic              dsc_valid_i,
  input logic [ADDR_W-1:0] dsc_addr_i,
  input logic              xfer_req_i,
  input logic              xfer_ack_i,
  input logic              done_i
);

  logic sema_wr, nxt_wr;
  assign sema_wr = reg_wr_i & (reg_addr_i == 2'd1);
  assign nxt_wr  = reg_wr_i & (reg_addr_i == 2'd0);

  a_r2_start_on_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_i && (sema_i != '0) && !halted_i) |=> dsc_req_i);

  a_r2_fetch_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dsc_req_i && !dsc_valid_i) |=> (dsc_req_i && $stable(dsc_addr_i)));

  a_r3_done_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> $past(xfer_req_i && xfer_ack_i));

  a_r3_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  a_r4_sema_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_i && !sema_wr) |=> $stable(sema_i));

  a_r6_zero_stays_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_i && (sema_i == '0)) |=> idle_i);

  a_r9_halt_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_i && halted_i && !nxt_wr) |=> idle_i);

  a_r10_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sema_i == '0) && !sema_wr) |=> (sema_i == '0));

  a_r10_cap_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&sema_i) && sema_wr && !done_i) |=> (&sema_i));

endmodule

bind dmaseq_chan_top dmaseq_chan_chk #(
  .ADDR_W(ADDR_W),
  .SEMA_W(SEMA_W)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_wr_i   (reg_wr_i),
  .reg_addr_i (reg_addr_i),
  .idle_i     (idle_o),
  .halted_i   (seq_halted),
  .sema_i     (sema_cnt),
  .dsc_req_i  (dsc_req_o),
  .dsc_valid_i(dsc_valid_i),
  .dsc_addr_i (dsc_addr_o),
  .xfer_req_i (xfer_req_o),
  .xfer_ack_i (xfer_ack_i),
  .done_i     (cmd_done_o)
);

// File: tb/dmaseq_chan_top_tb_top.sv
module dmaseq_chan_top_tb_top;

  logic        clk, rst_n;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        dsc_req, dsc_valid;
  logic [31:0] dsc_addr, dsc_rdata;
  logic        xfer_req, xfer_ack;
  logic [15:0] xfer_count;
  logic [31:0] xfer_buf;
  logic        cmd_done, cmd_irq, idle;

  logic        auto_ack, man_ack, hold_ack;
  logic [31:0] mem [0:63];
  logic [48:0] exp_q [$];
  int          n_chk, n_fail;
  logic        wd_fired;

  assign xfer_ack = auto_ack | man_ack;

  dmaseq_chan_top dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_wr_i    (reg_wr),
    .reg_addr_i  (reg_addr),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata),
    .dsc_req_o   (dsc_req),
    .dsc_addr_o  (dsc_addr),
    .dsc_valid_i (dsc_valid),
    .dsc_rdata_i (dsc_rdata),
    .xfer_req_o  (xfer_req),
    .xfer_count_o(xfer_count),
    .xfer_buf_o  (xfer_buf),
    .xfer_ack_i  (xfer_ack),
    .cmd_done_o  (cmd_done),
    .cmd_irq_o   (cmd_irq),
    .idle_o      (idle)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // descriptor memory model: answers each request on the following negedge
  always @(negedge clk) begin
    if (dsc_req && !dsc_valid) begin
      dsc_valid = 1'b1;
      dsc_rdata = mem[dsc_addr[7:2]];
    end else begin
      dsc_valid = 1'b0;
    end
  end

  // execution stub with optional hold
  always @(negedge clk) begin
    if (auto_ack) auto_ack = 1'b0;
    else if (xfer_req && !hold_ack) auto_ack = 1'b1;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && cmd_done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3 unexpected completion", {15'd0, cmd_irq, xfer_count, xfer_buf}, 64'd0);
      end else begin
        logic [48:0] e;
        e = exp_q.pop_front();
        check({cmd_irq, xfer_count, xfer_buf} == e, "R3 R5 completion item",
              {15'd0, cmd_irq, xfer_count, xfer_buf}, {15'd0, e});
      end
    end
  end

  function automatic logic [31:0] slot_addr(input int s);
    return 32'(s) << 4;
  endfunction

  task automatic put_desc(input int s, input int link, input bit chain, input bit dec,
                          input bit irq, input logic [15:0] cnt, input logic [31:0] bufa);
    mem[s*4 + 0] = slot_addr(link);
    mem[s*4 + 1] = {cnt, 13'd0, irq, dec, chain};
    mem[s*4 + 2] = bufa;
    mem[s*4 + 3] = 32'd0;
  endtask

  task automatic expect_slot(input int s);
    exp_q.push_back({mem[s*4 + 1][2], mem[s*4 + 1][31:16], mem[s*4 + 2]});
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    repeat (4) @(negedge clk);
    while (!idle) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic run_all();
    logic [31:0] d;
    // R1 reset state
    check(idle == 1'b1, "R1 idle", {63'd0, idle}, 64'd1);
    check(!dsc_req && !xfer_req, "R1 no requests", {62'd0, dsc_req, xfer_req}, 64'd0);
    rd(2'd1, d); check(d == 0, "R1 sema zero", {32'd0, d}, 64'd0);
    rd(2'd0, d); check(d == 0, "R1 next zero", {32'd0, d}, 64'd0);

    // R2 R5: three-command chain
    put_desc(0, 1, 1, 1, 0, 16'h0010, 32'hA000);
    put_desc(1, 2, 1, 1, 1, 16'h0020, 32'hA100);
    put_desc(2, 0, 0, 1, 0, 16'h0030, 32'hA200);
    expect_slot(0); expect_slot(1); expect_slot(2);
    wr(2'd0, slot_addr(0)); wr(2'd1, 32'd3);
    wait_idle();
    check(exp_q.size() == 0, "R2 chain all run", 64'(exp_q.size()), 64'd0);
    rd(2'd1, d); check(d == 0, "R4 sema drained", {32'd0, d}, 64'd0);
    rd(2'd0, d); check(d == slot_addr(2), "R5 next holds link", {32'd0, d}, {32'd0, slot_addr(2)});
    rd(2'd2, d); check(d == slot_addr(2), "R11 current descriptor", {32'd0, d}, {32'd0, slot_addr(2)});
    rd(2'd3, d); check(d == 0, "R11 reserved reads zero", {32'd0, d}, 64'd0);

    // R4: command without decrement does not consume
    put_desc(3, 4, 1, 0, 0, 16'h0040, 32'hA300);
    put_desc(4, 0, 0, 1, 1, 16'h0050, 32'hA400);
    expect_slot(3); expect_slot(4);
    wr(2'd0, slot_addr(3)); wr(2'd1, 32'd1);
    wait_idle();
    check(exp_q.size() == 0, "R4 non-decrement passes", 64'(exp_q.size()), 64'd0);
    rd(2'd1, d); check(d == 0, "R4 sema after", {32'd0, d}, 64'd0);

    // R6: stop at zero, resume from link
    put_desc(5, 6, 1, 1, 0, 16'h0060, 32'hA500);
    put_desc(6, 7, 1, 1, 0, 16'h0061, 32'hA600);
    put_desc(7, 8, 1, 1, 1, 16'h0062, 32'hA700);
    put_desc(8, 9, 1, 1, 0, 16'h0063, 32'hA800);
    put_desc(9, 0, 0, 1, 0, 16'h0064, 32'hA900);
    expect_slot(5); expect_slot(6);
    wr(2'd0, slot_addr(5)); wr(2'd1, 32'd2);
    wait_idle();
    repeat (10) @(negedge clk);
    check(idle && exp_q.size() == 0, "R6 stopped at zero", {63'd0, idle}, 64'd1);
    rd(2'd0, d); check(d == slot_addr(7), "R6 next is link", {32'd0, d}, {32'd0, slot_addr(7)});
    expect_slot(7); expect_slot(8); expect_slot(9);
    wr(2'd1, 32'd3);
    wait_idle();
    check(exp_q.size() == 0, "R6 resumed chain", 64'(exp_q.size()), 64'd0);

    // R7: add while running, R3 hold until ack
    put_desc(10, 11, 1, 1, 0, 16'h0070, 32'hAA00);
    put_desc(11, 12, 1, 1, 0, 16'h0071, 32'hAB00);
    put_desc(12, 0, 0, 1, 1, 16'h0072, 32'hAC00);
    expect_slot(10); expect_slot(11); expect_slot(12);
    hold_ack = 1'b1;
    wr(2'd0, slot_addr(10)); wr(2'd1, 32'd1);
    while (!xfer_req) @(negedge clk);
    wr(2'd1, 32'd2);
    rd(2'd1, d); check(d == 3, "R7 add while running", {32'd0, d}, 64'd3);
    repeat (6) @(negedge clk);
    check(xfer_req && xfer_count == 16'h0070, "R3 request held", {47'd0, xfer_req, xfer_count}, {47'd1, 16'h0070});
    hold_ack = 1'b0;
    wait_idle();
    check(exp_q.size() == 0, "R7 extended chain", 64'(exp_q.size()), 64'd0);

    // R8: add and decrement in one cycle
    put_desc(13, 14, 1, 1, 0, 16'h0080, 32'hAD00);
    put_desc(14, 0, 0, 1, 0, 16'h0081, 32'hAE00);
    expect_slot(13); expect_slot(14);
    hold_ack = 1'b1;
    wr(2'd0, slot_addr(13)); wr(2'd1, 32'd1);
    while (!xfer_req) @(negedge clk);
    man_ack = 1'b1;
    @(negedge clk);
    check(cmd_done == 1'b1, "R3 done after ack", {63'd0, cmd_done}, 64'd1);
    man_ack = 1'b0;
    reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'd1;
    @(negedge clk);
    reg_wr = 1'b0;
    check(cmd_done == 1'b0, "R3 done one cycle", {63'd0, cmd_done}, 64'd0);
    #1 check(reg_rdata == 1, "R8 net update", {32'd0, reg_rdata}, 64'd1);
    hold_ack = 1'b0;
    wait_idle();
    check(exp_q.size() == 0, "R8 chain continued", 64'(exp_q.size()), 64'd0);
    rd(2'd1, d); check(d == 0, "R8 final sema", {32'd0, d}, 64'd0);

    // R9: unchained command halts with count held
    put_desc(0, 0, 0, 1, 0, 16'h0090, 32'hB000);
    put_desc(1, 2, 1, 1, 0, 16'h0091, 32'hB100);
    put_desc(2, 0, 0, 1, 1, 16'h0092, 32'hB200);
    expect_slot(0);
    wr(2'd0, slot_addr(0)); wr(2'd1, 32'd3);
    wait_idle();
    repeat (20) @(negedge clk);
    check(idle && !dsc_req, "R9 halted idle", {63'd0, idle}, 64'd1);
    rd(2'd1, d); check(d == 2, "R9 count held", {32'd0, d}, 64'd2);
    expect_slot(1); expect_slot(2);
    wr(2'd0, slot_addr(1));
    wait_idle();
    check(exp_q.size() == 0, "R9 restart by next write", 64'(exp_q.size()), 64'd0);
    rd(2'd1, d); check(d == 0, "R9 count used", {32'd0, d}, 64'd0);

    // R10: saturation while halted
    wr(2'd1, 32'd200); wr(2'd1, 32'h0000_0164);
    rd(2'd1, d); check(d == 255, "R10 saturate high", {32'd0, d}, 64'd255);
    repeat (5) @(negedge clk);
    check(idle == 1'b1, "R9 still halted", {63'd0, idle}, 64'd1);
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
    dsc_valid = 1'b0; dsc_rdata = '0;
    auto_ack = 1'b0; man_ack = 1'b0; hold_ack = 1'b0;
    n_chk = 0; n_fail = 0; wd_fired = 1'b0;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    fork
      run_all();
      begin
        repeat (50000) @(posedge clk);
        wd_fired = 1'b1;
      end
    join_any
    disable fork;
    if (wd_fired) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule